// File: doc/BRIEF.md
# Cascaded Level Interrupt Controller

This block gathers 64 level-sensitive primary interrupt lines and steers each of them, under its own configuration word, to a normal interrupt output, a fast interrupt output, both, or neither. A select register lets software find out in one read whether a normal interrupt is waiting and which primary line raised it. When several lines are active together, the lowest-numbered one is reported.

Two small secondary groups of two lines each are built in. Each group has a read-only status register that shows the raw input levels and a mask register in which a 1 blocks the matching line. The OR of the unmasked lines of the first group takes the place of primary line 4, and that of the second group takes the place of primary line 5. The primary input pins at those two positions are therefore not used. All sources are levels: nothing is latched, and a source stops asserting only when its originator drops it. Software reaches the registers through a synchronous port with separate write and read strobes. Read data is registered.

Top module: `cascade_intc`

## Requirements
- R1: Primary line n has a configuration word at byte offset 4*n (n = 0..63). Bit 5 routes the line to `irq_o` and bit 6 routes it to `fiq_o`. A read returns only these two bits, and every other bit reads 0.
- R2: `irq_o` is high, in the same cycle, exactly when at least one active primary line has bit 5 set in its word.
- R3: `fiq_o` is high exactly when at least one active primary line has bit 6 set, independently of `irq_o`.
- R4: The select register at offset 0x104 reads with bit 6 set when any line routed by bit 5 is active, and bits 5:0 hold the number of the lowest-numbered such line. Lines routed only by bit 6 do not set it.
- R5: When no line routed by bit 5 is active, a read of the select register returns 0, so bit 6 reads clear.
- R6: The group status registers (offset 0x150 for the first group, 0x154 for the second) return the raw levels of that group's lines in bits 1:0. Writes to them are ignored.
- R7: The group mask registers (offset 0x168 for the first group, 0x16C for the second) are writable in bits 1:0 and read back. A mask bit of 1 blocks its line. The OR of the unmasked lines of the first group replaces primary line 4 and that of the second group replaces primary line 5. The `src_i` pins 4 and 5 have no effect.
- R8: After reset all routing bits are 0, both mask registers read 3, `irq_o` and `fiq_o` are low and `rdata_o` is 0.
- R9: Reads of unmapped offsets (including 0x100, 0x108 and misaligned addresses) return 0. Writes to them change no routing or mask state.
- R10: The outputs follow the source levels without latching. Dropping a source clears its contribution in the same cycle.
- R11: `rdata_o` is loaded on the clock edge at which `rd_en_i` is high and holds its value while `rd_en_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | 64 | Primary level sources (bits 4 and 5 unused) |
| sec_src_i | input | 4 | Secondary sources: bits 1:0 for the first group, bits 3:2 for the second |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 12 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Normal interrupt output |
| fiq_o | output | 1 | Fast interrupt output |

## Verification
A routing bit stored wrongly shows at once on `irq_o` or `fiq_o`: in the same cycle as the source is raised, and one cycle later as a wrong select value or readback. A mask register that is corrupted or wrongly decoded either lets a blocked secondary line through as primary line 4 or 5, or hides an enabled one, and this is visible as soon as that secondary line is driven. A priority error shows only when two routed lines are active together, so the tests pair lines on both sides of each other, including line 0 and line 63.

// File: rtl/cic_pkg.sv
package cic_pkg;
    localparam int IRQ_BIT   = 5;
    localparam int FIQ_BIT   = 6;
    localparam int PEND_BIT  = 6;
    localparam int CASC_BASE = 4;

    localparam logic [11:0] SEL_OFF = 12'h104;

    function automatic logic [11:0] stat_off(input int g);
        return 12'(12'h150 + 4 * g);
    endfunction

    function automatic logic [11:0] mask_off(input int g);
        return 12'(12'h168 + 4 * g);
    endfunction
endpackage

// File: rtl/cic_route_bank.sv
module cic_route_bank #(
    parameter int NUM_SRC = 64,
    localparam int IDX_W  = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic               wr_irq,
    input  logic               wr_fiq,
    output logic [NUM_SRC-1:0] route_irq_o,
    output logic [NUM_SRC-1:0] route_fiq_o
);
    typedef struct packed {
        logic [NUM_SRC-1:0] irq;
        logic [NUM_SRC-1:0] fiq;
    } route_t;

    route_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.irq[wr_idx] = wr_irq;
            st_d.fiq[wr_idx] = wr_fiq;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign route_irq_o = st_q.irq;
    assign route_fiq_o = st_q.fiq;

    assert_route_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(route_irq_o) && $stable(route_fiq_o));

    assert_route_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (route_irq_o[$past(wr_idx)] == $past(wr_irq)) &&
                  (route_fiq_o[$past(wr_idx)] == $past(wr_fiq)));
endmodule

// File: rtl/cic_sec_group.sv
module cic_sec_group #(
    parameter int GRP_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [GRP_W-1:0] wdata,
    input  logic [GRP_W-1:0] raw_i,
    output logic [GRP_W-1:0] mask_o,
    output logic             line_o
);
    logic [GRP_W-1:0] mask_d, mask_q;

    always_comb begin
        mask_d = mask_q;
        if (wr_en) mask_d = wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mask_q <= '1;
        else        mask_q <= mask_d;
    end

    assign mask_o = mask_q;
    assign line_o = |(raw_i & ~mask_q);

    assert_mask_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(mask_o));

    assert_all_blocked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (&mask_o) |-> !line_o);
endmodule

// File: rtl/cic_lowest_sel.sv
module cic_lowest_sel #(
    parameter int N      = 64,
    localparam int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     vec_i,
    output logic             hit_o,
    output logic [IDX_W-1:0] idx_o
);
    always_comb begin
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec_i[i]) idx_o = IDX_W'(i);
        end
        hit_o = |vec_i;
    end
endmodule

// File: rtl/cascade_intc.sv
module cascade_intc #(
    parameter int NUM_SRC = 64,
    parameter int NUM_GRP = 2,
    parameter int GRP_W   = 2,
    parameter int ADDR_W  = 12,
    parameter int DATA_W  = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_SRC-1:0]       src_i,
    input  logic [NUM_GRP*GRP_W-1:0] sec_src_i,
    input  logic                     wr_en_i,
    input  logic                     rd_en_i,
    input  logic [ADDR_W-1:0]        addr_i,
    input  logic [DATA_W-1:0]        wdata_i,
    output logic [DATA_W-1:0]        rdata_o,
    output logic                     irq_o,
    output logic                     fiq_o
);
    import cic_pkg::*;

    localparam int IDX_W   = $clog2(NUM_SRC);
    localparam int CFG_TOP = 4 * NUM_SRC;

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } top_state_t;

    top_state_t st_d, st_q;

    logic                          cfg_hit;
    logic [IDX_W-1:0]              cfg_idx;
    logic [NUM_SRC-1:0]            route_irq, route_fiq;
    logic [NUM_SRC-1:0]            lvl, act_irq, act_fiq;
    logic [NUM_GRP-1:0]            grp_line;
    logic [NUM_GRP-1:0][GRP_W-1:0] grp_mask;
    logic                          sel_hit;
    logic [IDX_W-1:0]              sel_idx;
    logic [DATA_W-1:0]             rd_val;
    logic                          unused_wdata;

    assign unused_wdata = ^wdata_i;

    assign cfg_hit = (addr_i[1:0] == 2'b00) && (32'(addr_i) < 32'(CFG_TOP));
    assign cfg_idx = addr_i[IDX_W+1:2];

    cic_route_bank #(.NUM_SRC(NUM_SRC)) u_route (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en_i && cfg_hit),
        .wr_idx      (cfg_idx),
        .wr_irq      (wdata_i[IRQ_BIT]),
        .wr_fiq      (wdata_i[FIQ_BIT]),
        .route_irq_o (route_irq),
        .route_fiq_o (route_fiq)
    );

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        cic_sec_group #(.GRP_W(GRP_W)) u_grp (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (wr_en_i && (addr_i == ADDR_W'(mask_off(g)))),
            .wdata  (wdata_i[GRP_W-1:0]),
            .raw_i  (sec_src_i[g*GRP_W +: GRP_W]),
            .mask_o (grp_mask[g]),
            .line_o (grp_line[g])
        );
    end

    always_comb begin
        lvl = src_i;
        for (int g = 0; g < NUM_GRP; g++) begin
            lvl[CASC_BASE + g] = grp_line[g];
        end
    end

    assign act_irq = lvl & route_irq;
    assign act_fiq = lvl & route_fiq;
    assign irq_o   = |act_irq;
    assign fiq_o   = |act_fiq;

    cic_lowest_sel #(.N(NUM_SRC)) u_sel (
        .vec_i (act_irq),
        .hit_o (sel_hit),
        .idx_o (sel_idx)
    );

    always_comb begin
        rd_val = '0;
        if (cfg_hit) begin
            rd_val[IRQ_BIT] = route_irq[cfg_idx];
            rd_val[FIQ_BIT] = route_fiq[cfg_idx];
        end else if (addr_i == ADDR_W'(SEL_OFF)) begin
            if (sel_hit) begin
                rd_val[PEND_BIT]    = 1'b1;
                rd_val[IDX_W-1:0]   = sel_idx;
            end
        end else begin
            for (int g = 0; g < NUM_GRP; g++) begin
                if (addr_i == ADDR_W'(stat_off(g)))
                    rd_val[GRP_W-1:0] = sec_src_i[g*GRP_W +: GRP_W];
                if (addr_i == ADDR_W'(mask_off(g)))
                    rd_val[GRP_W-1:0] = grp_mask[g];
            end
        end
    end

    always_comb begin
        st_d = st_q;
        if (rd_en_i) st_d.rdata = rd_val;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata_o = st_q.rdata;

    assert_sel_active_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sel_hit |-> act_irq[sel_idx]);

    assert_sel_lowest_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sel_hit |-> ((act_irq & ((NUM_SRC'(1) << sel_idx) - NUM_SRC'(1))) == '0));

    assert_irq_unrouted_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (route_irq == '0) |-> !irq_o);

    assert_fiq_unrouted_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (route_fiq == '0) |-> !fiq_o);

    assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en_i |=> $stable(rdata_o));
endmodule

// File: tb/sim_cascade_intc.sv
module sim_cascade_intc;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] src_i = '0;
    logic [3:0]  sec_src_i = '0;
    logic        wr_en_i = 1'b0, rd_en_i = 1'b0;
    logic [11:0] addr_i = '0;
    logic [31:0] wdata_i = '0;
    logic [31:0] rdata_o;
    logic        irq_o, fiq_o;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    cascade_intc u0 (
        .clk(clk), .rst_n(rst_n), .src_i(src_i), .sec_src_i(sec_src_i),
        .wr_en_i(wr_en_i), .rd_en_i(rd_en_i), .addr_i(addr_i),
        .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o), .fiq_o(fiq_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en_i = 1'b1; addr_i = a; wdata_i = d;
        @(negedge clk);
        wr_en_i = 1'b0; wdata_i = '0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en_i = 1'b1; addr_i = a;
        @(negedge clk);
        rd_en_i = 1'b0;
        d = rdata_o;
    endtask

    task automatic set_src(input logic [63:0] s, input logic [3:0] sec);
        @(negedge clk);
        src_i = s; sec_src_i = sec;
        #1;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk("R8 irq after reset", {31'b0, irq_o}, 0);
        chk("R8 fiq after reset", {31'b0, fiq_o}, 0);
        chk("R8 rdata after reset", rdata_o, 0);
        rd(12'h000, v); chk("R8 cfg0 reset", v, 0);
        rd(12'h0FC, v); chk("R8 cfg63 reset", v, 0);
        rd(12'h168, v); chk("R8 mask0 reset", v, 3);
        rd(12'h16C, v); chk("R8 mask1 reset", v, 3);
    endtask

    task automatic t_cfg_rw();
        logic [31:0] v;
        wr(12'h028, 32'hFFFF_FFFF);
        rd(12'h028, v); chk("R1 cfg10 all ones", v, 32'h60);
        wr(12'h0FC, 32'h20);
        rd(12'h0FC, v); chk("R1 cfg63 irq only", v, 32'h20);
        wr(12'h028, 32'h0);
        rd(12'h028, v); chk("R1 cfg10 cleared", v, 0);
    endtask

    task automatic t_irq_route();
        set_src(64'h400, 4'h0);
        chk("R2 masked source no irq", {31'b0, irq_o}, 0);
        wr(12'h028, 32'h20); #1;
        chk("R2 routed source irq", {31'b0, irq_o}, 1);
        chk("R3 irq-only no fiq", {31'b0, fiq_o}, 0);
        set_src(64'h0, 4'h0);
        chk("R10 drop clears irq", {31'b0, irq_o}, 0);
        set_src(64'h400, 4'h0);
        chk("R10 reraise irq", {31'b0, irq_o}, 1);
    endtask

    task automatic t_fiq_route();
        logic [31:0] v;
        wr(12'h050, 32'h40);
        set_src(64'h10_0000, 4'h0);
        chk("R3 fiq routed", {31'b0, fiq_o}, 1);
        chk("R2 fiq-only no irq", {31'b0, irq_o}, 0);
        rd(12'h104, v); chk("R4 fiq-only no pending", v, 0);
        set_src(64'h0, 4'h0);
        chk("R10 drop clears fiq", {31'b0, fiq_o}, 0);
    endtask

    task automatic t_select();
        logic [31:0] v;
        wr(12'h00C, 32'h20);
        wr(12'h000, 32'h20);
        set_src(64'h8000_0000_0000_0400, 4'h0);
        rd(12'h104, v); chk("R4 lowest of 10,63", v, 32'h4A);
        set_src(64'h8000_0000_0000_0408, 4'h0);
        rd(12'h104, v); chk("R4 lowest of 3,10,63", v, 32'h43);
        set_src(64'h8000_0000_0000_0000, 4'h0);
        rd(12'h104, v); chk("R4 only 63", v, 32'h7F);
        set_src(64'h8000_0000_0000_0001, 4'h0);
        rd(12'h104, v); chk("R4 source 0 pending", v, 32'h40);
    endtask

    task automatic t_empty();
        logic [31:0] v;
        set_src(64'h0, 4'h0);
        rd(12'h104, v); chk("R5 nothing pending", v, 0);
        chk("R5 irq low", {31'b0, irq_o}, 0);
    endtask

    task automatic t_sec_status();
        logic [31:0] v;
        set_src(64'h0, 4'b1001);
        rd(12'h150, v); chk("R6 group0 status", v, 1);
        rd(12'h154, v); chk("R6 group1 status", v, 2);
        wr(12'h150, 32'h3);
        rd(12'h150, v); chk("R6 status write ignored", v, 1);
        set_src(64'h0, 4'h0);
    endtask

    task automatic t_cascade();
        logic [31:0] v;
        wr(12'h010, 32'h20);
        wr(12'h014, 32'h40);
        set_src(64'h30, 4'h0);
        chk("R7 pin4 ignored", {31'b0, irq_o}, 0);
        chk("R7 pin5 ignored", {31'b0, fiq_o}, 0);
        set_src(64'h0, 4'b0001);
        chk("R7 masked group0", {31'b0, irq_o}, 0);
        wr(12'h168, 32'h2); #1;
        chk("R7 unmasked group0 irq", {31'b0, irq_o}, 1);
        rd(12'h104, v); chk("R7 select shows line 4", v, 32'h44);
        rd(12'h168, v); chk("R7 mask0 readback", v, 2);
        set_src(64'h0, 4'b0010);
        chk("R7 group0 bit1 still masked", {31'b0, irq_o}, 0);
        set_src(64'h0, 4'b0100);
        chk("R7 masked group1", {31'b0, fiq_o}, 0);
        wr(12'h16C, 32'h0); #1;
        chk("R7 unmasked group1 fiq", {31'b0, fiq_o}, 1);
        set_src(64'h0, 4'h0);
        chk("R10 group drop clears fiq", {31'b0, fiq_o}, 0);
    endtask

    task automatic t_unmapped();
        logic [31:0] v;
        wr(12'h100, 32'hFFFF_FFFF);
        wr(12'h108, 32'hFFFF_FFFF);
        wr(12'h104, 32'hFFFF_FFFF);
        rd(12'h100, v); chk("R9 read 0x100", v, 0);
        rd(12'h108, v); chk("R9 read 0x108", v, 0);
        rd(12'h002, v); chk("R9 misaligned read", v, 0);
        rd(12'h000, v); chk("R9 cfg0 untouched", v, 32'h20);
        rd(12'h0FC, v); chk("R9 cfg63 untouched", v, 32'h20);
        rd(12'h168, v); chk("R9 mask0 untouched", v, 2);
        set_src(64'h0, 4'h0);
        chk("R9 no stray irq", {31'b0, irq_o}, 0);
    endtask

    task automatic t_rd_hold();
        logic [31:0] v;
        rd(12'h000, v); chk("R11 read loads", v, 32'h20);
        @(negedge clk); addr_i = 12'h168;
        @(negedge clk);
        chk("R11 holds without strobe", rdata_o, 32'h20);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_cfg_rw();
        t_irq_route();
        t_fiq_route();
        t_select();
        t_empty();
        t_sec_status();
        t_cascade();
        t_unmapped();
        t_rd_hold();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule